// File: doc/BRIEF.md
# SDRAM Refresh Request Timer

This block paces SDRAM refresh for a memory controller. It holds a free-running prescaler, an 8-bit up-counter, an 8-bit period constant and a small control/status word. A clock-select field picks one prescaler output to act as the counter's count tick. When a tick arrives while the counter equals the constant, the counter restarts from zero, a sticky match flag is set and a one-cycle refresh request is sent to the command sequencer. An interrupt can be raised from the flag.

Software reaches the block over a plain 32-bit register bus. Every write must carry the key 0xA55A in its upper half-word, or it is dropped. The match flag cannot be cleared by a blind write: software must first read the control/status word and see the flag at 1, and then write a 0 into it.

Top module: `sdram_refresh_timer`

## Requirements
- R1: After a synchronous reset every register, the read data, `irq_o` and `refresh_req_o` are 0.
- R2: A write takes effect only when `bus_wdata[31:16]` equals 0xA55A; with any other key the addressed register keeps its value.
- R3: Word address 0 selects the control/status word, 1 the counter, 2 the period constant; address 3 reads 0. Counter and constant read back zero-extended, bits 31:8 always read 0. Read data is registered: it shows the selected word in the cycle after `bus_re` and holds otherwise.
- R4: Control/status layout: bit 7 match flag, bit 6 interrupt enable, bits 5:3 clock select, bits 2:0 refresh-count field, stored and read back exactly as written.
- R5: Clock select 1 to 7 gives one count tick every 4, 16, 64, 256, 1024, 2048 and 4096 input clocks; select 0 gives no ticks, so the counter holds its value.
- R6: When a count tick arrives while the counter equals the constant, after that edge the counter is 0, the flag is 1 and `refresh_req_o` is high for exactly one cycle. A counter write in the same cycle wins over the restart.
- R7: An accepted control/status write with bit 7 = 0 clears the flag only if a read of that word returned the flag as 1 since the last accepted control/status write; writing 1 to bit 7 has no effect, and a new match in the same cycle keeps the flag set.
- R8: `irq_o` is 1 exactly while both the flag and the interrupt enable are 1.
- R9: The prescaler phase is cleared only by reset; changing the clock select does not realign it, so the first tick after a change arrives at the next multiple of the divisor counted from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Word address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, key in bits 31:16 |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Match interrupt |
| refresh_req_o | output | 1 | One-cycle refresh request pulse |

## Verification
The assertions assume that the bus never strobes a read and a write in the same cycle and that strobes last one cycle; the bench tasks issue exactly one one-cycle access at a time. The single-cycle request check relies on the shortest possible period being four clocks, which every select code and constant value guarantees. The bench drives every select code, keyed and unkeyed writes to each register, blind and armed flag clears, and select changes at arbitrary prescaler phases, while a behavioural model tracks the expected outputs on every clock.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_COUNT = 2'd1;
  localparam logic [1:0] A_LIMIT = 2'd2;

  // log2 of the prescaler divisor for each clock-select code (0 = stopped)
  function automatic int unsigned div_shift(input logic [2:0] sel);
    case (sel)
      3'd1: div_shift = 2;
      3'd2: div_shift = 4;
      3'd3: div_shift = 6;
      3'd4: div_shift = 8;
      3'd5: div_shift = 10;
      3'd6: div_shift = 11;
      3'd7: div_shift = 12;
      default: div_shift = 0;
    endcase
  endfunction
endpackage

// File: rtl/srt_prescaler.sv
module srt_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [7:0]       hit;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  assign hit[0] = 1'b0;
  for (genvar c = 1; c < 8; c++) begin : g_tap
    localparam int SH = srt_pkg::div_shift(3'(c));
    assign hit[c] = &pre_q[SH-1:0];
  end

  assign tick = hit[sel];
endmodule

// File: rtl/srt_counter.sv
module srt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cnt_we,
  input  logic             lim_we,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] lim_q,
  output logic             match,
  output logic             req_q
);
  assign match = tick && (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= match;
      if (lim_we) lim_q <= wr_val;
      if (cnt_we)     cnt_q <= wr_val;
      else if (match) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/srt_ctrl.sv
module srt_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wd,
  input  logic       match,
  output logic       flag_q,
  output logic       ien_q,
  output logic [2:0] sel_q,
  output logic [2:0] rcnt_q,
  output logic       armed_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q   <= 1'b0;
      sel_q   <= '0;
      rcnt_q  <= '0;
      armed_q <= 1'b0;
    end else if (wr_en) begin
      ien_q   <= wd[6];
      sel_q   <= wd[5:3];
      rcnt_q  <= wd[2:0];
      armed_q <= 1'b0;
    end else if (rd_en && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                             flag_q <= 1'b0;
    else if (match)                      flag_q <= 1'b1;
    else if (wr_en && armed_q && !wd[7]) flag_q <= 1'b0;
  end
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int          DATA_W = 32,
  parameter int          ADDR_W = 2,
  parameter int          CNT_W  = 8,
  parameter int          PRE_W  = 12,
  parameter logic [15:0] KEY    = 16'hA55A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              refresh_req_o
);
  import srt_pkg::*;

  logic             key_ok, ctrl_wr, cnt_wr, lim_wr, ctrl_rd;
  logic             tick, match;
  logic             flag, ien, armed;
  logic [2:0]       sel, rcnt;
  logic [CNT_W-1:0] cnt, lim;
  logic [DATA_W-1:0] rd_mux;

  assign key_ok  = bus_we && (bus_wdata[DATA_W-1 -: 16] == KEY);
  assign ctrl_wr = key_ok && (bus_addr == A_CTRL);
  assign cnt_wr  = key_ok && (bus_addr == A_COUNT);
  assign lim_wr  = key_ok && (bus_addr == A_LIMIT);
  assign ctrl_rd = bus_re && (bus_addr == A_CTRL);

  srt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .sel(sel), .tick(tick)
  );

  srt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .cnt_we(cnt_wr), .lim_we(lim_wr), .wr_val(bus_wdata[CNT_W-1:0]),
    .cnt_q(cnt), .lim_q(lim), .match(match), .req_q(refresh_req_o)
  );

  srt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_en(ctrl_wr), .rd_en(ctrl_rd),
    .wd(bus_wdata[7:0]), .match(match),
    .flag_q(flag), .ien_q(ien), .sel_q(sel), .rcnt_q(rcnt), .armed_q(armed)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL:  rd_mux[7:0]       = {flag, ien, sel, rcnt};
      A_COUNT: rd_mux[CNT_W-1:0] = cnt;
      A_LIMIT: rd_mux[CNT_W-1:0] = lim;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  assign irq_o = flag & ien;
endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
  parameter int          DATA_W = 32,
  parameter int          CNT_W  = 8,
  parameter logic [15:0] KEY    = 16'hA55A
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              refresh_req_o,
  input logic              flag,
  input logic              ien,
  input logic              armed,
  input logic [2:0]        sel,
  input logic [2:0]        rcnt,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  lim
);
  localparam int TOP_W = (CNT_W > 8) ? CNT_W : 8;

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata >> TOP_W) == '0);

  p_bad_key_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_wdata[DATA_W-1 -: 16] != KEY) |=>
      ($stable(lim) && $stable(sel) && $stable(ien) && $stable(rcnt)));

  p_stopped_r5: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd0 && !(bus_we && bus_addr == 2'd1)) |=> $stable(cnt));

  p_req_flag_r6: assert property (@(posedge clk) disable iff (rst)
    refresh_req_o |-> flag);

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    refresh_req_o |=> !refresh_req_o);

  p_clear_armed_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(armed));
endmodule

bind sdram_refresh_timer srt_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .refresh_req_o(refresh_req_o),
  .flag(flag), .ien(ien), .armed(armed), .sel(sel), .rcnt(rcnt),
  .cnt(cnt), .lim(lim)
);

// File: tb/sim_sdram_refresh_timer.sv
`timescale 1ns/1ps
module sim_sdram_refresh_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_o, refresh_req_o;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    started = 1'b0;
  bit    done = 1'b0;
  string phase = "R1 reset";

  always #2.5 clk = ~clk;

  sdram_refresh_timer u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .refresh_req_o(refresh_req_o)
  );

  // behavioural reference
  int          m_pre, m_cnt, m_lim, m_sel, m_rc;
  bit          m_flag, m_en, m_armed, m_req;
  logic [31:0] m_rdata;

  function automatic int divisor(input int code);
    case (code)
      1: return 4;     2: return 16;    3: return 64;   4: return 256;
      5: return 1024;  6: return 2048;  7: return 4096;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_cnt = 0; m_lim = 0; m_sel = 0; m_rc = 0;
      m_flag = 0; m_en = 0; m_armed = 0; m_req = 0; m_rdata = 0;
    end else begin
      bit tk, hit, okw, newflag;
      tk = (m_sel != 0) && ((m_pre % divisor(m_sel)) == divisor(m_sel) - 1);
      m_pre = (m_pre + 1) % 4096;
      hit = tk && (m_cnt == m_lim);
      okw = bus_we && (bus_wdata[31:16] == 16'hA55A);
      if (bus_re) begin
        case (bus_addr)
          2'd0: m_rdata = {24'd0, m_flag, m_en, 3'(m_sel), 3'(m_rc)};
          2'd1: m_rdata = 32'(m_cnt);
          2'd2: m_rdata = 32'(m_lim);
          default: m_rdata = 0;
        endcase
      end
      newflag = m_flag;
      if (hit) newflag = 1;
      else if (okw && bus_addr == 0 && m_armed && !bus_wdata[7]) newflag = 0;
      if (okw && bus_addr == 0) begin
        m_en = bus_wdata[6]; m_sel = int'(bus_wdata[5:3]); m_rc = int'(bus_wdata[2:0]);
        m_armed = 0;
      end else if (bus_re && bus_addr == 0 && m_flag) m_armed = 1;
      m_flag = newflag;
      if (okw && bus_addr == 2) m_lim = int'(bus_wdata[7:0]);
      if (okw && bus_addr == 1) m_cnt = int'(bus_wdata[7:0]);
      else if (hit) m_cnt = 0;
      else if (tk) m_cnt = (m_cnt + 1) % 256;
      m_req = hit;
    end
  end

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", phase, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check(32'(irq_o), 32'(m_flag & m_en), "irq (R8)");
      check(32'(refresh_req_o), 32'(m_req), "refresh request (R6)");
      check(bus_rdata, m_rdata, "read data (R3)");
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    #1 bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input bit f, input bit e, input int s, input int r);
    return {16'hA55A, 8'd0, f, e, 3'(s), 3'(r)};
  endfunction

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    started = 1'b1;
    @(negedge clk); #1 rst = 1'b0;

    phase = "R1 reset";
    rd(2'd0, d); check(d, 32'd0, "control word after reset");
    rd(2'd1, d); check(d, 32'd0, "counter after reset");

    phase = "R2 key";
    wr(2'd0, 32'h0000_00FF);
    wr(2'd2, 32'h1234_0077);
    rd(2'd0, d); check(d, 32'd0, "control word after unkeyed write");
    rd(2'd2, d); check(d, 32'd0, "constant after unkeyed write");

    phase = "R3 map";
    wr(2'd2, 32'hA55A_FF05);
    rd(2'd2, d); check(d, 32'h0000_0005, "constant readback zero-extended");
    rd(2'd3, d); check(d, 32'd0, "unused address");

    phase = "R4 fields";
    wr(2'd0, ctl(1, 1, 1, 3));
    rd(2'd0, d); check(d & 32'hFFFF_FF7F, 32'h0000_004B, "control fields readback");

    phase = "R6 match";
    idle(80);

    phase = "R7 clear";
    while (!irq_o) @(negedge clk);
    wr(2'd0, ctl(0, 1, 1, 3));
    rd(2'd0, d); check(32'(d[7]), 32'd1, "flag after blind write of 0");
    wr(2'd0, ctl(0, 1, 1, 3));
    idle(30);
    wr(2'd0, ctl(1, 1, 1, 3));
    idle(10);

    phase = "R8 irq";
    wr(2'd0, ctl(1, 0, 1, 3));
    idle(30);
    wr(2'd0, ctl(1, 1, 1, 3));
    idle(5);

    phase = "R5 select";
    for (int c = 1; c < 8; c++) begin
      wr(2'd2, 32'hA55A_0001);
      wr(2'd0, ctl(1, 1, c, c));
      idle(2 * divisor(c) + 12);
    end
    wr(2'd0, ctl(1, 1, 0, 2));
    rd(2'd1, d);
    begin
      logic [31:0] d2;
      idle(40);
      rd(2'd1, d2); check(d2, d, "counter held with select 0");
    end
    wr(2'd1, 32'hA55A_0042);
    rd(2'd1, d); check(d, 32'h0000_0042, "counter write readback");

    phase = "R9 phase";
    idle(7);
    wr(2'd2, 32'hA55A_0000);
    wr(2'd0, ctl(1, 1, 3, 0));
    idle(150);
    idle(13);
    wr(2'd0, ctl(1, 1, 2, 0));
    idle(60);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog in %s: got timeout expected completion", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule